// File: doc/BRIEF.md
# Amplifier Sticky Status and Control Register

This block keeps the one-byte status word of a power amplifier and applies the one-byte control word that a host writes to it. Seven of the eight status bits are latched condition flags. Hardware sets a flag with a single-cycle event pulse, and the flag holds until the host clears it. The remaining bit records whether the amplifier is online. Only a host write can bring the amplifier online. Either a host write or any shutdown condition can take it offline.

The serial front end presents each decoded control write as a one-cycle strobe together with its data byte. It reads `status_byte` back for the host. `amp_enable` drives the amplifier's bias or RF enable. Both outputs are registered and change one clock after the event or write that causes them.

Top module: `amp_status_ctrl`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `status_byte` is 0x20 (only the reset flag is set) and `amp_enable` is 0.
- R2: A pulse on a condition input sets its status bit at the next clock edge. The bit positions are: 7 fan fail, 5 amplifier reset, 4 reverse-power shutdown, 3 overdrive alarm, 2 thermal alarm, 1 overdrive shutdown, 0 thermal shutdown.
- R3: A set flag stays set on every following cycle until a host write clears it.
- R4: A control write with a 1 in bit b (b not 6) clears flag b. A 0 in that bit leaves the flag unchanged.
- R5: If a condition event and a write-one clear hit the same flag in the same cycle, the flag ends set.
- R6: Status bit 6 (online) becomes 1 only through a control write with data bit 6 equal to 1.
- R7: A control write with data bit 6 equal to 0 makes bit 6 read 0 after the next edge.
- R8: A reverse-power, overdrive or thermal shutdown event clears bit 6 at the next edge.
- R9: A control write of 1 to bit 6 in the same cycle as any shutdown event is ignored, and the amplifier stays offline.
- R10: `amp_enable` equals status bit 6 on every cycle.
- R11: Fan fail, reset, overdrive alarm and thermal alarm events do not change bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fan_fail_evt | input | 1 | One-cycle fan failure event |
| amp_reset_evt | input | 1 | One-cycle amplifier reset event |
| rev_pwr_sd_evt | input | 1 | One-cycle reverse-power shutdown event |
| ovd_alarm_evt | input | 1 | One-cycle overdrive alarm event |
| therm_alarm_evt | input | 1 | One-cycle thermal alarm event |
| ovd_sd_evt | input | 1 | One-cycle overdrive shutdown event |
| therm_sd_evt | input | 1 | One-cycle thermal shutdown event |
| ctrl_wr | input | 1 | Control-word write strobe |
| ctrl_data | input | 8 | Control-word data byte |
| status_byte | output | 8 | Latched status word |
| amp_enable | output | 1 | Amplifier online enable |

## Verification
The bench targets four collisions:
- A condition event and a clear of the same bit in one cycle. A design that lets the clear win loses an alarm.
- A write of 1 to the online bit during a shutdown event. A design that lets the write win turns on an amplifier that is faulting.
- Writes of 0 to flag positions. A design that treats the control byte as a plain overwrite or as write-zero-to-clear wipes or keeps the wrong flags.
- Non-shutdown events. A design that wires them into the shutdown path drops the amplifier offline on a mere alarm.

A long stream of mixed pseudo-random events and writes is compared against a behavioural model on every cycle. This catches wrong bit positions and wrong reset values.

// File: rtl/amp_stat_pkg.sv
// Shared constants for the amplifier status word: width, bit positions,
// the set of bits that force shutdown, and the reset pattern.
package amp_stat_pkg;
    localparam int STAT_W        = 8;
    localparam int BIT_FAN       = 7;
    localparam int BIT_ONLINE    = 6;
    localparam int BIT_RESET     = 5;
    localparam int BIT_REV_SD    = 4;
    localparam int BIT_OVD_ALM   = 3;
    localparam int BIT_THERM_ALM = 2;
    localparam int BIT_OVD_SD    = 1;
    localparam int BIT_THERM_SD  = 0;

    // Bits whose event also forces the amplifier offline.
    localparam logic [STAT_W-1:0] SHUTDOWN_MASK =
        (STAT_W'(1) << BIT_REV_SD) | (STAT_W'(1) << BIT_OVD_SD) |
        (STAT_W'(1) << BIT_THERM_SD);

    // Status word value right after reset.
    localparam logic [STAT_W-1:0] RESET_PATTERN = STAT_W'(1) << BIT_RESET;
endpackage

// File: rtl/sticky_flag.sv
// One latched condition flag, set by hardware and cleared by writing 1.
// Assumes: set_i and clr_i are synchronous single-cycle qualifiers.
// When both arrive in the same cycle, the set wins.
module sticky_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    // Flag register: set has priority over clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= RST_VAL;
        else if (set_i)  q <= 1'b1;
        else if (clr_i)  q <= 1'b0;
    end

    assign q_o = q;

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/online_latch.sv
// Online state of the amplifier.
// Assumes: sd_evt_i is the OR of all shutdown events in this cycle. A host
// write supplies the requested state in wr_val_i. Shutdown dominates, so
// a write of 1 coinciding with a shutdown is dropped.
module online_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sd_evt_i,
    input  logic wr_i,
    input  logic wr_val_i,
    output logic online_o
);
    logic online;

    // Online register: shutdown forces 0, else a host write loads its bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         online <= 1'b0;
        else if (sd_evt_i)  online <= 1'b0;
        else if (wr_i)      online <= wr_val_i;
    end

    assign online_o = online;

    p_shutdown_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sd_evt_i |=> !online_o);
    p_write_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wr_val_i) |=> !online_o);
    p_blocked_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_evt_i && wr_i && wr_val_i) |=> !online_o);
    p_online_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_evt_i && !wr_i) |=> $stable(online_o));
endmodule

// File: rtl/amp_status_ctrl.sv
// Amplifier status and control register.
// Gathers the condition pulses into a vector and builds one flag cell per
// status bit, with the online latch at the online position. It exposes the
// registered word and the enable.
// Assumes: ctrl_wr and every event input are single-cycle synchronous pulses.
module amp_status_ctrl
    import amp_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fan_fail_evt,
    input  logic              amp_reset_evt,
    input  logic              rev_pwr_sd_evt,
    input  logic              ovd_alarm_evt,
    input  logic              therm_alarm_evt,
    input  logic              ovd_sd_evt,
    input  logic              therm_sd_evt,
    input  logic              ctrl_wr,
    input  logic [STAT_W-1:0] ctrl_data,
    output logic [STAT_W-1:0] status_byte,
    output logic              amp_enable
);
    logic [STAT_W-1:0] evt_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] stat_q;
    logic              sd_any;

    // Map named event pulses onto their status bit positions.
    always_comb begin
        evt_vec                = '0;
        evt_vec[BIT_FAN]       = fan_fail_evt;
        evt_vec[BIT_RESET]     = amp_reset_evt;
        evt_vec[BIT_REV_SD]    = rev_pwr_sd_evt;
        evt_vec[BIT_OVD_ALM]   = ovd_alarm_evt;
        evt_vec[BIT_THERM_ALM] = therm_alarm_evt;
        evt_vec[BIT_OVD_SD]    = ovd_sd_evt;
        evt_vec[BIT_THERM_SD]  = therm_sd_evt;
    end

    // Per-bit clear qualifier: a write strobe with a 1 in that position.
    assign clr_vec = ctrl_data & {STAT_W{ctrl_wr}};
    assign sd_any  = |(evt_vec & SHUTDOWN_MASK);

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (i == BIT_ONLINE) begin : g_online
            online_latch u_online (
                .clk      (clk),
                .rst_n    (rst_n),
                .sd_evt_i (sd_any),
                .wr_i     (ctrl_wr),
                .wr_val_i (ctrl_data[i]),
                .online_o (stat_q[i])
            );
        end else begin : g_flag
            sticky_flag #(.RST_VAL(RESET_PATTERN[i])) u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (evt_vec[i]),
                .clr_i (clr_vec[i]),
                .q_o   (stat_q[i])
            );
        end
    end

    assign status_byte = stat_q;
    assign amp_enable  = stat_q[BIT_ONLINE];

    p_online_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(amp_enable) |-> $past(ctrl_wr && ctrl_data[BIT_ONLINE] && !sd_any));
    p_shutdown_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sd_any |=> (status_byte & SHUTDOWN_MASK) != '0);
endmodule

// File: tb/amp_status_ctrl_bench.sv
module amp_status_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt = '0;        // bit positions as in R2; bit 6 unused
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_data = '0;
    logic [7:0] status_byte;
    logic       amp_enable;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [7:0] m_stat = 8'h20;
    logic       model_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amp_status_ctrl u_amp_status_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .fan_fail_evt    (evt[7]),
        .amp_reset_evt   (evt[5]),
        .rev_pwr_sd_evt  (evt[4]),
        .ovd_alarm_evt   (evt[3]),
        .therm_alarm_evt (evt[2]),
        .ovd_sd_evt      (evt[1]),
        .therm_sd_evt    (evt[0]),
        .ctrl_wr         (ctrl_wr),
        .ctrl_data       (ctrl_data),
        .status_byte     (status_byte),
        .amp_enable      (amp_enable)
    );

    // Behavioural reference model, updated on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = 8'h20;
        end else begin
            logic [7:0] nxt;
            bit sd;
            nxt = m_stat;
            sd = evt[4] || evt[1] || evt[0];
            for (int b = 0; b < 8; b++) begin
                if (b == 6) begin
                    if (sd) nxt[b] = 1'b0;
                    else if (ctrl_wr) nxt[b] = ctrl_data[b];
                end else if (evt[b]) begin
                    nxt[b] = 1'b1;
                end else if (ctrl_wr && ctrl_data[b]) begin
                    nxt[b] = 1'b0;
                end
            end
            m_stat = nxt;
        end
    end

    // Model comparison on every falling edge once enabled (R10 included).
    always @(negedge clk) begin
        if (model_on) begin
            n_checks++;
            if (status_byte !== m_stat) begin
                n_fail++;
                $display("FAIL R3 model compare: status actual %02h expected %02h", status_byte, m_stat);
            end
            n_checks++;
            if (amp_enable !== m_stat[6]) begin
                n_fail++;
                $display("FAIL R10 enable: actual %0b expected %0b", amp_enable, m_stat[6]);
            end
        end
    end

    // Watchdog: counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Drive one cycle of stimulus, then return inputs to idle.
    task automatic drive(input logic [7:0] e, input logic w, input logic [7:0] d);
        @(negedge clk);
        evt = e; ctrl_wr = w; ctrl_data = d;
        @(negedge clk);
        evt = '0; ctrl_wr = 1'b0; ctrl_data = '0;
    endtask

    task automatic chk(input logic [7:0] exp, input string req);
        n_checks++;
        if (status_byte !== exp || amp_enable !== exp[6]) begin
            n_fail++;
            $display("FAIL %s: status %02h en %0b expected status %02h en %0b",
                     req, status_byte, amp_enable, exp, exp[6]);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        chk(8'h20, "R1 reset state");
        rst_n = 1'b1;
        model_on = 1'b1;
        drive(8'h00, 1'b0, 8'h00); chk(8'h20, "R1 after release");
        drive(8'h00, 1'b1, 8'h20); chk(8'h00, "R4 clear reset flag");
        drive(8'h00, 1'b1, 8'h40); chk(8'h40, "R6 host online");
        drive(8'h80, 1'b0, 8'h00); chk(8'hC0, "R2 R11 fan fail");
        drive(8'h00, 1'b0, 8'h00);
        drive(8'h00, 1'b0, 8'h00); chk(8'hC0, "R3 sticky");
        drive(8'h00, 1'b1, 8'h00); chk(8'h80, "R7 R4 write zero");
        drive(8'h00, 1'b1, 8'h40); chk(8'hC0, "R6 online again");
        drive(8'h04, 1'b0, 8'h00); chk(8'hC4, "R11 thermal alarm keeps online");
        drive(8'h08, 1'b1, 8'h48); chk(8'hCC, "R5 set beats clear");
        drive(8'h10, 1'b0, 8'h00); chk(8'h9C, "R8 reverse power shutdown");
        drive(8'h01, 1'b1, 8'h40); chk(8'h9D, "R9 online write blocked");
        drive(8'h00, 1'b1, 8'h40); chk(8'hDD, "R6 online after block");
        drive(8'h02, 1'b0, 8'h00); chk(8'h9F, "R8 overdrive shutdown");
        drive(8'h00, 1'b1, 8'hBF); chk(8'h00, "R4 clear all");
        drive(8'h20, 1'b0, 8'h00); chk(8'h20, "R2 reset event");
        drive(8'h00, 1'b1, 8'h60); chk(8'h40, "R4 R6 clear and online");
        drive(8'hAC, 1'b0, 8'h00); chk(8'hEC, "R11 non-shutdown events");
        // Mixed pseudo-random traffic checked by the model each cycle.
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(negedge clk);
            evt = (lfsr[3:0] == 4'd0) ? (lfsr[15:8] & 8'hBF) : 8'h00;
            ctrl_wr = lfsr[5] & lfsr[6];
            ctrl_data = lfsr[13:6];
        end
        @(negedge clk);
        evt = '0; ctrl_wr = 1'b0; ctrl_data = '0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(8'h20, "R1 second reset");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule